// File: doc/BRIEF.md
# Asynchronous Strobe Bus to Wishbone Master Bridge

This bridge lets a processor with an SRAM-style, unclocked bus reach a synchronous Wishbone bus. The bridge acts as the Wishbone master. The processor presents an address, byte enables and active-low chip enable, read and write strobes. For a write it also puts data on the shared data bus. The bridge brings the three control levels into its clock domain through a flop chain. When chip enable and one strobe are both seen active, it runs exactly one single Wishbone transfer.

While the transfer runs, the bridge pulls its active-low wait output low. It releases wait when the slave terminates the cycle. For a read, the returned word is registered and then driven onto the shared data bus. The bridge drives that bus only while chip enable and the read strobe are low and no write is in progress. At all other times the bus is left high-impedance. The bridge waits for the processor to drop its strobe or chip enable before it accepts another access, so a long strobe gives one transfer.

Top module: `async_wb_bridge`

## Requirements
- R1: After the synchronous active-high reset, `wb_cyc_o` and `wb_stb_o` are low and `ext_wait_n` is high.
- R2: A transfer starts only when `ext_ce_n` is low together with `ext_rd_n` or `ext_wr_n` low. Chip enable alone, or a strobe alone, starts nothing. Either one may come first.
- R3: `ext_wait_n` goes low in the same clock as `wb_cyc_o` rises. It stays low while the cycle runs and returns high in the clock where the cycle ends.
- R4: `wb_sel_o` equals the bitwise inverse of `ext_be_n` captured at access start, with one bit per data byte.
- R5: For a write, `wb_we_o` is 1, `wb_adr_o` equals `ext_addr`, and `wb_dat_o` equals the word on `ext_data` at access start. These values stay stable for the whole cycle.
- R6: For a read, `wb_we_o` is 0. The word on `wb_dat_i` at the acknowledge is driven on `ext_data` once wait is released. It stays there unchanged, whatever `wb_dat_i` does, until the read strobe is released.
- R7: With a slave that acknowledges in the same clock as the strobe, `wb_cyc_o` is high for exactly one clock.
- R8: `wb_err_i` or `wb_rty_i` ends the cycle and releases wait exactly as `wb_ack_i` does.
- R9: Each access produces exactly one cycle, however long the strobe is held. The next cycle needs the strobe or chip enable to go inactive first.
- R10: The bridge drives `ext_data` only while `ext_ce_n` and `ext_rd_n` are low and no write is active. During writes, the bus carries the processor's value undisturbed.
- R11: `wb_cyc_o` rises on the third rising clock edge after chip enable and a strobe are both low: two synchroniser flops plus one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_adr_o | output | ADDR_W | Wishbone address |
| wb_sel_o | output | DATA_W/8 | Wishbone byte select |
| wb_dat_o | output | DATA_W | Wishbone write data |
| wb_dat_i | input | DATA_W | Wishbone read data |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error termination |
| wb_rty_i | input | 1 | Wishbone retry termination |
| ext_data | inout | DATA_W | Shared processor data bus |
| ext_addr | input | ADDR_W | Processor address |
| ext_rd_n | input | 1 | Read strobe, active low |
| ext_wr_n | input | 1 | Write strobe, active low |
| ext_ce_n | input | 1 | Chip enable, active low |
| ext_be_n | input | DATA_W/8 | Byte enables, active low |
| ext_wait_n | output | 1 | Wait to processor, active low |

## Verification
After the second strobe condition is applied at a falling edge, the cycle is due after the third rising edge. The bench samples `wb_cyc_o` low after the second edge and high after the third. Termination is due one edge after the slave responds. The bench's slave answers after a chosen number of strobe clocks, so the bench expects the drop exactly that many clocks plus one later, with wait released in the same sample. Read data is checked on the bus in the sample after the drop, and checked again several clocks later after the slave has changed its data. Every sample is taken at the falling edge, half a period away from the registers.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2,
    ST_HOLD = 2'd3
  } bridge_state_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= INIT;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= INIT;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n_s,
  input  logic              rd_n_s,
  input  logic              wr_n_s,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [SEL_W-1:0]  ext_be_n,
  input  logic [DATA_W-1:0] ext_data_in,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              wb_we_o,
  output logic              wb_cyc_o,
  input  logic              wb_ack_i,
  input  logic              wb_err_i,
  input  logic              wb_rty_i,
  output logic              wait_n,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_active
);
  bridge_state_t state;
  logic start, term, released;

  assign start    = !ce_n_s && (!rd_n_s || !wr_n_s);
  assign released = ce_n_s || (rd_n_s && wr_n_s);
  assign term     = wb_ack_i || wb_err_i || wb_rty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      wb_cyc_o <= 1'b0;
      wait_n   <= 1'b1;
      wb_we_o  <= 1'b0;
      wb_adr_o <= '0;
      wb_sel_o <= '0;
      wb_dat_o <= '0;
      rdata    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_BUS;
          wb_cyc_o <= 1'b1;
          wait_n   <= 1'b0;
          wb_we_o  <= !wr_n_s;
          wb_adr_o <= ext_addr;
          wb_sel_o <= ~ext_be_n;
          wb_dat_o <= ext_data_in;
        end
        ST_BUS: if (term) begin
          state    <= ST_DONE;
          wb_cyc_o <= 1'b0;
          wait_n   <= 1'b1;
          if (wb_ack_i && !wb_we_o) rdata <= wb_dat_i;
        end
        ST_DONE: state <= released ? ST_IDLE : ST_HOLD;
        default: if (released) state <= ST_IDLE;
      endcase
    end
  end

  assign wr_active = wb_we_o && (state != ST_IDLE);

  AST_WAIT_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wb_cyc_o |-> !wait_n); // R3
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && term) |=> (!wb_cyc_o && wait_n)); // R8
  AST_START_QUAL: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_cyc_o) |-> $past(!ce_n_s && (!rd_n_s || !wr_n_s))); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && $past(wb_cyc_o)) |-> ($stable(wb_adr_o) && $stable(wb_sel_o) && $stable(wb_dat_o))); // R5
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_cyc_o) |=> !wb_cyc_o); // R9
endmodule

// File: rtl/async_wb_bridge.sv
module async_wb_bridge #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              wb_we_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  input  logic              wb_ack_i,
  input  logic              wb_err_i,
  input  logic              wb_rty_i,
  inout  wire  [DATA_W-1:0] ext_data,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_rd_n,
  input  logic              ext_wr_n,
  input  logic              ext_ce_n,
  input  logic [SEL_W-1:0]  ext_be_n,
  output logic              ext_wait_n
);
  logic [2:0]        ctl_s;
  logic [DATA_W-1:0] rdata;
  logic              wr_active, cyc, bus_oe;

  bridge_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_ce_n, ext_rd_n, ext_wr_n}),
    .q   (ctl_s)
  );

  bridge_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ce_n_s      (ctl_s[2]),
    .rd_n_s      (ctl_s[1]),
    .wr_n_s      (ctl_s[0]),
    .ext_addr    (ext_addr),
    .ext_be_n    (ext_be_n),
    .ext_data_in (ext_data),
    .wb_adr_o    (wb_adr_o),
    .wb_sel_o    (wb_sel_o),
    .wb_dat_o    (wb_dat_o),
    .wb_dat_i    (wb_dat_i),
    .wb_we_o     (wb_we_o),
    .wb_cyc_o    (cyc),
    .wb_ack_i    (wb_ack_i),
    .wb_err_i    (wb_err_i),
    .wb_rty_i    (wb_rty_i),
    .wait_n      (ext_wait_n),
    .rdata       (rdata),
    .wr_active   (wr_active)
  );

  assign wb_cyc_o = cyc;
  assign wb_stb_o = cyc;

  assign bus_oe   = !ext_ce_n && !ext_rd_n && ext_wr_n && !wr_active;
  assign ext_data = bus_oe ? rdata : {DATA_W{1'bz}};

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!ext_wr_n || wr_active) |-> !bus_oe); // R10
  AST_NO_DRIVE_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    ext_ce_n |-> !bus_oe); // R10
endmodule

// File: tb/sim_async_wb_bridge.sv
`timescale 1ns/1ps
module sim_async_wb_bridge;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int SW = DW / 8;

  typedef struct packed {
    bit          we;
    bit          lead_ce;
    bit [1:0]    lead;
    bit [AW-1:0] addr;
    bit [DW-1:0] data;
    bit [SW-1:0] be_n;
    bit [1:0]    dly;
    bit [1:0]    kind;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 20'h12345, 16'hBEEF, 2'b00, 2'd0, 2'd0},
    '{1'b1, 1'b0, 2'd2, 20'h00F0F, 16'h1234, 2'b10, 2'd1, 2'd0},
    '{1'b0, 1'b1, 2'd3, 20'hFFFFF, 16'h0001, 2'b01, 2'd2, 2'd0},
    '{1'b1, 1'b0, 2'd0, 20'h80000, 16'hA5A5, 2'b11, 2'd0, 2'd1},
    '{1'b0, 1'b0, 2'd0, 20'h00001, 16'h7E7E, 2'b00, 2'd1, 2'd2},
    '{1'b1, 1'b1, 2'd1, 20'h55555, 16'h0000, 2'b00, 2'd3, 2'd0},
    '{1'b0, 1'b1, 2'd1, 20'h2AAAA, 16'h0F0F, 2'b10, 2'd0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] wb_adr_o;
  logic [SW-1:0] wb_sel_o;
  logic [DW-1:0] wb_dat_o, wb_dat_i;
  logic wb_we_o, wb_cyc_o, wb_stb_o, wb_ack_i, wb_err_i, wb_rty_i;
  wire  [DW-1:0] ext_data;
  logic [AW-1:0] ext_addr = '0;
  logic ext_rd_n = 1'b1, ext_wr_n = 1'b1, ext_ce_n = 1'b1;
  logic [SW-1:0] ext_be_n = '1;
  logic ext_wait_n;
  logic [DW-1:0] tb_drv = '0;
  logic tb_oe = 1'b0;

  assign ext_data = tb_oe ? tb_drv : {DW{1'bz}};

  // slave model: responds after resp_dly clocks of strobe
  logic [1:0] resp_dly = 2'd0, resp_kind = 2'd0, hold_cnt;
  logic resp;
  logic [DW-1:0] slave_rdata = '0;
  assign resp     = wb_stb_o && (hold_cnt == resp_dly);
  assign wb_ack_i = resp && (resp_kind == 2'd0);
  assign wb_err_i = resp && (resp_kind == 2'd1);
  assign wb_rty_i = resp && (resp_kind == 2'd2);
  assign wb_dat_i = slave_rdata;
  always_ff @(posedge clk) begin
    if (!wb_stb_o || resp) hold_cnt <= 2'd0;
    else                   hold_cnt <= hold_cnt + 2'd1;
  end

  async_wb_bridge u0 (
    .clk(clk), .rst(rst),
    .wb_adr_o(wb_adr_o), .wb_sel_o(wb_sel_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_we_o(wb_we_o), .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o),
    .wb_ack_i(wb_ack_i), .wb_err_i(wb_err_i), .wb_rty_i(wb_rty_i),
    .ext_data(ext_data), .ext_addr(ext_addr), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_ce_n(ext_ce_n), .ext_be_n(ext_be_n), .ext_wait_n(ext_wait_n)
  );

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v);
    slave_rdata = v.data;
    resp_kind   = v.kind;
    resp_dly    = v.dly;
    @(negedge clk);
    ext_addr = v.addr;
    ext_be_n = v.be_n;
    if (v.we) begin tb_drv = v.data; tb_oe = 1'b1; end
    if (v.lead != 2'd0) begin
      if (v.lead_ce) ext_ce_n = 1'b0;
      else if (v.we) ext_wr_n = 1'b0;
      else           ext_rd_n = 1'b0;
      for (int k = 0; k < int'(v.lead) + 3; k++) begin
        @(negedge clk);
        chk(!wb_cyc_o && ext_wait_n, "R2 partial select", {30'd0, wb_cyc_o, ext_wait_n}, 32'h1);
      end
    end
    ext_ce_n = 1'b0;
    if (v.we) ext_wr_n = 1'b0; else ext_rd_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!wb_cyc_o, "R11 early", wb_cyc_o, 0);
    @(negedge clk);
    chk(wb_cyc_o && wb_stb_o, "R11 start", {wb_cyc_o, wb_stb_o}, 2'b11);
    chk(!ext_wait_n, "R3 wait low", ext_wait_n, 0);
    chk(wb_adr_o == v.addr, "R5 addr", wb_adr_o, v.addr);
    chk(wb_sel_o == ~v.be_n, "R4 sel", wb_sel_o, ~v.be_n);
    if (v.we) begin
      chk(wb_we_o, "R5 we", wb_we_o, 1);
      chk(wb_dat_o == v.data, "R5 wdata", wb_dat_o, v.data);
      chk(ext_data == v.data, "R10 bus undisturbed", ext_data, v.data);
    end else begin
      chk(!wb_we_o, "R6 we", wb_we_o, 0);
    end
    for (int k = 0; k < int'(v.dly); k++) begin
      @(negedge clk);
      chk(wb_cyc_o && !ext_wait_n, "R3 held", {wb_cyc_o, ext_wait_n}, 2'b10);
    end
    @(negedge clk);
    if (v.kind != 2'd0)
      chk(!wb_cyc_o && ext_wait_n, "R8 err/rty end", {wb_cyc_o, ext_wait_n}, 2'b01);
    else if (v.dly == 2'd0)
      chk(!wb_cyc_o && ext_wait_n, "R7 single clock", {wb_cyc_o, ext_wait_n}, 2'b01);
    else
      chk(!wb_cyc_o && ext_wait_n, "R3 release", {wb_cyc_o, ext_wait_n}, 2'b01);
    if (!v.we && v.kind == 2'd0) begin
      chk(ext_data == v.data, "R6 read data", ext_data, v.data);
      slave_rdata = ~v.data;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!wb_cyc_o, "R9 one cycle", wb_cyc_o, 0);
    end
    if (!v.we && v.kind == 2'd0)
      chk(ext_data == v.data, "R6 hold", ext_data, v.data);
    if (v.we)
      chk(ext_data == v.data, "R10 bus during write", ext_data, v.data);
    ext_ce_n = 1'b1; ext_rd_n = 1'b1; ext_wr_n = 1'b1; tb_oe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wb_cyc_o && !wb_stb_o && ext_wait_n, "R1 reset", {wb_cyc_o, wb_stb_o, ext_wait_n}, 3'b001);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: read strobe without chip enable leaves the bus to the bench
    @(negedge clk);
    ext_rd_n = 1'b0; tb_drv = 16'h5A5A; tb_oe = 1'b1;
    repeat (5) @(negedge clk);
    chk(ext_data == 16'h5A5A, "R10 not selected", ext_data, 16'h5A5A);
    chk(!wb_cyc_o, "R2 strobe only", wb_cyc_o, 0);
    ext_rd_n = 1'b1; tb_oe = 1'b0;

    // R2 and R9: after release a fresh access runs again
    run_vec('{1'b0, 1'b0, 2'd0, 20'h0ABCD, 16'hC3C3, 2'b00, 2'd0, 2'd0});

    // R1: reset in the middle of an access
    @(negedge clk);
    ext_ce_n = 1'b0; ext_rd_n = 1'b0; resp_dly = 2'd3;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!wb_cyc_o && ext_wait_n, "R1 reset mid access", {wb_cyc_o, ext_wait_n}, 2'b01);
    ext_ce_n = 1'b1; ext_rd_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule